// File: doc/BRIEF.md
# Interrupt Controller with Edge Pulse Stretcher

This block collects a vector of status flags from a display-controller core and reduces them to a single active-high interrupt line toward a host processor. Each flag is first brought into the bus clock domain through a two-flop synchronizer. It is then conditioned in one of two ways. In level mode the synchronized flag passes straight through. In edge mode every rising edge of the flag starts a pulse whose length, in bus clocks, comes from a programmable count.

A per-flag enable mask gates each conditioned flag. The interrupt output is the registered OR of all enabled, conditioned flags. The mask is never written as a whole word. One address sets the bits written as 1, and a second address clears the bits written as 1.

One flag source is built in: a low-fill detector for an input FIFO. It compares the live fill count against a threshold register. The host can choose whether this flag tracks the live condition or holds once set. The host sees a simple single-cycle write port and a registered read port.

Top module: `irq_stretch_ctrl`

## Requirements
- R1: After reset, irq_o is 0, the mask reads 0, the trigger-mode word reads all ones (every flag edge-triggered), and the pulse length, threshold and hold control read 0.
- R2: A write to address 0 sets every mask bit whose data bit is 1, and a write to address 1 clears every mask bit whose data bit is 1. Other mask bits keep their value. A read of either address returns the mask.
- R3: For a flag in level mode (trigger bit 0 at address 2), irq_o rises at the third bus clock edge after the flag input rises and falls at the third edge after it falls.
- R4: For a flag in edge mode (trigger bit 1) with pulse length L from 1 to 63 (address 3, bits 5:0), one rising edge of the input gives an irq_o pulse of exactly L cycles, starting at the fourth clock edge.
- R5: In edge mode with a pulse length of 0, rising edges of the flag never raise irq_o.
- R6: A rising edge that is detected while a pulse is still running reloads the count to L. This includes an edge detected in the pulse's last cycle, so the pulses merge into one high period with no gap.
- R7: A flag whose mask bit is 0 never raises irq_o. irq_o is high whenever any enabled, conditioned flag is high.
- R8: Flag bit 3 is driven internally and is high when fifo_fill is less than or equal to the threshold at address 4. The external input on bit 3 is ignored. In level mode irq_o follows a fill change at the fourth clock edge.
- R9: When bit 0 of address 5 is 1, the low-fill flag holds once it is set, even after the fill rises above the threshold. Writing that bit back to 0 returns the flag to tracking the live comparison.
- R10: rdata shows the register selected by addr one clock edge later. Narrower fields are returned zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| flags_async | input | NUM_FLAGS | Status flags from the core clock domain |
| fifo_fill | input | FILL_W | Input FIFO fill count in the bus clock domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | NUM_FLAGS | Write data |
| rdata | output | NUM_FLAGS | Registered read data |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
Two stretcher actions can fall in the same cycle: the count reaching its final value, and a newly detected rising edge that must reload it. The bench provokes this by re-raising an edge-mode flag exactly L bus clocks after the first rise, so that detection lands on the cycle where the count is 1. It then counts the high cycles of irq_o and the number of separate high runs. A correct reload gives one unbroken run of 2L cycles. If the decrement wins, the second edge is lost and the bench sees L cycles or a gap.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [2:0] ADDR_MASK_SET = 3'd0;
  localparam logic [2:0] ADDR_MASK_CLR = 3'd1;
  localparam logic [2:0] ADDR_TRIG     = 3'd2;
  localparam logic [2:0] ADDR_PLEN     = 3'd3;
  localparam logic [2:0] ADDR_LOWTH    = 3'd4;
  localparam logic [2:0] ADDR_HOLD     = 3'd5;
  localparam int unsigned LOW_FILL_BIT = 3;
endpackage

// File: rtl/irq_host_regs.sv
module irq_host_regs #(
  parameter int NUM_FLAGS = 32,
  parameter int CNT_W     = 6,
  parameter int FILL_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [NUM_FLAGS-1:0] wdata,
  output logic [NUM_FLAGS-1:0] rdata,
  output logic [NUM_FLAGS-1:0] mask,
  output logic [NUM_FLAGS-1:0] trig_edge,
  output logic [CNT_W-1:0]     plen,
  output logic [FILL_W-1:0]    low_thr,
  output logic                 hold
);
  import irq_pkg::*;

  logic [NUM_FLAGS-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    case (addr)
      ADDR_MASK_SET, ADDR_MASK_CLR: rd_n = mask;
      ADDR_TRIG:  rd_n = trig_edge;
      ADDR_PLEN:  rd_n[CNT_W-1:0] = plen;
      ADDR_LOWTH: rd_n[FILL_W-1:0] = low_thr;
      ADDR_HOLD:  rd_n[0] = hold;
      default:    rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= '0;
      trig_edge <= '1;
      plen      <= '0;
      low_thr   <= '0;
      hold      <= 1'b0;
      rdata     <= '0;
    end else begin
      rdata <= rd_n;
      if (wr_en) begin
        case (addr)
          ADDR_MASK_SET: mask      <= mask | wdata;
          ADDR_MASK_CLR: mask      <= mask & ~wdata;
          ADDR_TRIG:     trig_edge <= wdata;
          ADDR_PLEN:     plen      <= wdata[CNT_W-1:0];
          ADDR_LOWTH:    low_thr   <= wdata[FILL_W-1:0];
          ADDR_HOLD:     hold      <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R2: set address turns on every written-one bit
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_MASK_SET) |=> ((mask & $past(wdata)) == $past(wdata)));
  // R2: clear address turns off every written-one bit
  assert_mask_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_MASK_CLR) |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/irq_flag_sync.sv
module irq_flag_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/irq_low_fill.sv
module irq_low_fill #(
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] thr,
  input  logic              hold,
  output logic              low_q
);
  always_ff @(posedge clk) begin
    if (rst) low_q <= 1'b0;
    else     low_q <= (fill <= thr) | (hold & low_q);
  end

  // R9: a set flag in hold mode stays set
  assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (hold && low_q) |=> low_q);
endmodule

// File: rtl/irq_pulse_stretch.sv
module irq_pulse_stretch #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             edge_mode,
  input  logic [CNT_W-1:0] plen,
  output logic             cond
);
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = sync_in & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= sync_in;
      if (rise)             cnt <= plen;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  assign cond = edge_mode ? (cnt != '0) : sync_in;

  // R5: a zero length never starts a pulse
  assert_len0_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (plen == '0 && cnt == '0) |=> (cnt == '0));
  // R6: an edge during a running pulse reloads the full length
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (rise && cnt != '0) |=> (cnt == $past(plen)));
endmodule

// File: rtl/irq_stretch_ctrl.sv
module irq_stretch_ctrl #(
  parameter int NUM_FLAGS = 32,
  parameter int CNT_W     = 6,
  parameter int FILL_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flags_async,
  input  logic [FILL_W-1:0]    fifo_fill,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [NUM_FLAGS-1:0] wdata,
  output logic [NUM_FLAGS-1:0] rdata,
  output logic                 irq_o
);
  import irq_pkg::*;

  logic [NUM_FLAGS-1:0] mask, trig_edge, raw, synced, cond;
  logic [CNT_W-1:0]     plen;
  logic [FILL_W-1:0]    low_thr;
  logic                 hold, low_q;

  irq_host_regs #(.NUM_FLAGS(NUM_FLAGS), .CNT_W(CNT_W), .FILL_W(FILL_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mask(mask), .trig_edge(trig_edge), .plen(plen),
    .low_thr(low_thr), .hold(hold)
  );

  irq_low_fill #(.FILL_W(FILL_W)) low_i (
    .clk(clk), .rst(rst), .fill(fifo_fill), .thr(low_thr), .hold(hold), .low_q(low_q)
  );

  always_comb begin
    raw = flags_async;
    raw[LOW_FILL_BIT] = low_q;
  end

  irq_flag_sync #(.WIDTH(NUM_FLAGS)) sync_i (
    .clk(clk), .rst(rst), .d_async(raw), .q_sync(synced)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    irq_pulse_stretch #(.CNT_W(CNT_W)) stretch_i (
      .clk(clk), .rst(rst), .sync_in(synced[g]), .edge_mode(trig_edge[g]),
      .plen(plen), .cond(cond[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(cond & mask);
  end

  // R7: the request line needs at least one enabled source
  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(mask) != '0));
endmodule

// File: tb/irq_stretch_ctrl_tb.sv
module irq_stretch_ctrl_tb_top;
  localparam int NF = 32;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] flags_async = '0;
  logic [FW-1:0] fifo_fill = 8'd200;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [NF-1:0] wdata = '0;
  logic [NF-1:0] rdata;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_stretch_ctrl #(.NUM_FLAGS(NF), .CNT_W(6), .FILL_W(FW)) dut_i (
    .clk(clk), .rst(rst), .flags_async(flags_async), .fifo_fill(fifo_fill),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NF-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NF-1:0] v);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  // Drives flag b high at step 0, low at step hi, optionally high again at
  // step again for one cycle; records first high step, high count, high runs.
  task automatic run_flag(input int b, input int hi, input int again,
                          output int first, output int total, output int runs);
    bit last = 1'b0;
    first = -1; total = 0; runs = 0;
    flags_async[b] = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (irq_o) begin
        total++;
        if (first < 0) first = i;
        if (!last) runs++;
      end
      last = irq_o;
      if (i == hi) flags_async[b] = 1'b0;
      if (again > 0 && i == again) flags_async[b] = 1'b1;
      if (again > 0 && i == again + 1) flags_async[b] = 1'b0;
    end
  endtask

  task automatic settle();
    flags_async = '0;
    wr(3'd1, '1);
    wr(3'd2, '1);
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NF-1:0] v;
    chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    rd(3'd0, v); chk(v == '0, "R1 mask reset", v, 0);
    rd(3'd2, v); chk(v == '1, "R1 trig reset", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk(v == '0, "R1 plen reset", v, 0);
    rd(3'd4, v); chk(v == '0, "R1 thr reset", v, 0);
    rd(3'd5, v); chk(v == '0, "R1 hold reset", v, 0);
  endtask

  task automatic t_mask();
    logic [NF-1:0] v;
    wr(3'd0, 32'h0000_00F0);
    wr(3'd0, 32'h0000_0003);
    rd(3'd0, v); chk(v == 32'hF3, "R2 set accumulates", v, 32'hF3);
    rd(3'd1, v); chk(v == 32'hF3, "R2 read via clear addr", v, 32'hF3);
    wr(3'd1, 32'h0000_0030);
    rd(3'd0, v); chk(v == 32'hC3, "R2 clear selected bits", v, 32'hC3);
    wr(3'd1, '1);
    rd(3'd0, v); chk(v == '0, "R2 clear all", v, 0);
  endtask

  task automatic t_regs();
    logic [NF-1:0] v;
    wr(3'd3, 32'hFFFF_FF2A);
    rd(3'd3, v); chk(v == 32'h2A, "R10 plen zero-extended", v, 32'h2A);
    wr(3'd4, 32'h0000_1E77);
    rd(3'd4, v); chk(v == 32'h77, "R10 thr zero-extended", v, 32'h77);
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, v); chk(v == 32'h1234_5678, "R10 trig readback", v, 32'h1234_5678);
    wr(3'd3, '0); wr(3'd4, '0); wr(3'd2, '1);
  endtask

  task automatic t_level();
    int f, t, r;
    wr(3'd2, ~32'h0000_0020);
    wr(3'd0, 32'h0000_0020);
    run_flag(5, 4, 0, f, t, r);
    chk(f == 3, "R3 level rise latency", f, 3);
    chk(t == 4, "R3 level follows width", t, 4);
    settle();
  endtask

  task automatic t_edge(input int len);
    int f, t, r;
    wr(3'd3, len);
    wr(3'd0, 32'h0000_0400);
    run_flag(10, 1, 0, f, t, r);
    if (len == 0) begin
      chk(t == 0, "R5 zero length silent", t, 0);
    end else begin
      chk(f == 4, "R4 edge pulse start", f, 4);
      chk(t == len, "R4 edge pulse length", t, len);
    end
    settle();
  endtask

  task automatic t_restart();
    int f, t, r;
    wr(3'd3, 5);
    wr(3'd0, 32'h0000_0400);
    run_flag(10, 1, 2, f, t, r);
    chk(t == 7, "R6 restart mid pulse", t, 7);
    chk(r == 1, "R6 restart single run", r, 1);
    settle();
  endtask

  task automatic t_coincide();
    int f, t, r;
    wr(3'd3, 5);
    wr(3'd0, 32'h0000_0400);
    run_flag(10, 1, 5, f, t, r);
    chk(t == 10, "R6 edge on last count", t, 10);
    chk(r == 1, "R6 no gap on last count", r, 1);
    settle();
  endtask

  task automatic t_masking();
    int f, t, r;
    wr(3'd2, '0);
    wr(3'd0, 32'h0000_0220);
    run_flag(7, 4, 0, f, t, r);
    chk(t == 0, "R7 masked flag silent", t, 0);
    run_flag(5, 4, 0, f, t, r);
    chk(t == 4, "R7 OR via flag 5", t, 4);
    run_flag(9, 4, 0, f, t, r);
    chk(t == 4, "R7 OR via flag 9", t, 4);
    settle();
  endtask

  task automatic t_lowfill();
    int f;
    wr(3'd2, '0);
    wr(3'd4, 1);
    wr(3'd0, 32'h0000_0008);
    repeat (6) @(negedge clk);
    flags_async[3] = 1'b1;
    repeat (8) @(negedge clk);
    chk(irq_o == 1'b0, "R8 external bit3 ignored", irq_o, 0);
    flags_async[3] = 1'b0;
    fifo_fill = 8'd1;
    f = -1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (irq_o && f < 0) f = i;
    end
    chk(f == 4, "R8 fill equal to thr latency", f, 4);
    fifo_fill = 8'd2;
    repeat (8) @(negedge clk);
    chk(irq_o == 1'b0, "R8 fill above thr", irq_o, 0);
    fifo_fill = 8'd0;
    repeat (8) @(negedge clk);
    chk(irq_o == 1'b1, "R8 fill below thr", irq_o, 1);
    wr(3'd5, 1);
    repeat (4) @(negedge clk);
    fifo_fill = 8'd9;
    repeat (10) @(negedge clk);
    chk(irq_o == 1'b1, "R9 hold keeps flag", irq_o, 1);
    wr(3'd5, 0);
    repeat (8) @(negedge clk);
    chk(irq_o == 1'b0, "R9 release tracks live", irq_o, 0);
    fifo_fill = 8'd200;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_regs();
    t_level();
    t_edge(1);
    t_edge(7);
    t_edge(63);
    t_edge(0);
    t_restart();
    t_coincide();
    t_masking();
    t_lowfill();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule